// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Unit

This block is the interrupt register bank of a serial peripheral interface controller. Every cycle it samples event sources from the transmit and receive FIFOs and from the transfer engine, and it latches them into a sticky status register. Software clears status bits by writing ones to them. A separate enable mask decides which latched events reach the single interrupt line. Software never writes the mask directly. It writes ones to a set-only register to enable bits and ones to a clear-only register to disable bits, and it reads the result through a read-only view.

The block also holds a programmable transmit watermark. When the transmit FIFO fill level drops under this threshold, an event is raised once, on the crossing, and it stays latched until software clears it. This lets a driver refill the FIFO in bursts. The receive-data-available event is level driven, so a driver can drain the receive FIFO by polling that status bit until it reads zero.

The register port is a plain address, write strobe and write data, with combinational read data. The FIFO fill levels and the mode-fault line arrive as level inputs. The FIFOs and the serial shifter are outside this block.

Top module: `spi_irq_regbank`

## Requirements
- R1: After reset the status reads 0, the mask reads 0, the watermark reads 1 and the interrupt output is low.
- R2: A write to the enable register (offset 0x08) sets the mask bits where the data has ones. Zero bits leave the mask unchanged, so writing 0 has no effect. The mask reads back at offset 0x10 in bits 6:0.
- R3: A write to the disable register (offset 0x0C) clears the mask bits where the data has ones. Zero bits leave the mask unchanged.
- R4: Writing to the status register (offset 0x04) clears exactly the status bits where the data has ones. Writing back a value read from status therefore returns status to zero while no source is active.
- R5: Status bit 1 (mode fault) is set on the edge after the mode-fault input is high. It stays set after the input drops, until it is cleared.
- R6: Status bit 3 (transmit FIFO full) is set on the edge after the transmit level equals the FIFO depth.
- R7: Status bit 4 (receive data available) is set on every edge while the receive level is nonzero. A clear of bit 4 therefore has no visible effect until the receive level is zero.
- R8: Status bit 2 (transmit below watermark) is set only on the edge where (transmit level < watermark) changes from false to true. It stays latched while the level rises again. It does not set again while the level stays below.
- R9: The watermark register at offset 0x28 is read/write and holds the low clog2(depth+1) bits of the written data. The higher bits read as zero.
- R10: The interrupt output is high exactly when some bit is set in both status and mask.
- R11: Reads of the enable register, the disable register and any unmapped offset return 0. Writes to the mask view (0x10) leave the mask unchanged.
- R12: When a status bit is cleared and its source is active on the same edge, the set wins and the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W | Register byte offset |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for regAddr, combinational |
| txLevel | input | LVL_W | Current transmit FIFO fill level |
| rxLevel | input | LVL_W | Current receive FIFO fill level |
| modeFault | input | 1 | Mode-fault indication from the transfer engine |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest case to bring about is the watermark event. It depends on the history of the transmit level and not on its current value. To exercise it, the stimulus walks the level down one step at a time from full, for every threshold from 0 to the depth. It checks the latched bit after each step against (level < threshold). It then clears the bit while the level stays low, to show that no retrigger happens. A second hard case is a clear that meets an active source on the same edge. Holding the receive level or the mode-fault input high across a clear write produces it.

// File: rtl/spi_irq_pkg.sv
`timescale 1ns/1ps
package spi_irq_pkg;
  localparam int unsigned IRQ_BITS = 7;

  localparam int unsigned BIT_MODE_FAULT = 1;
  localparam int unsigned BIT_TX_LOW     = 2;
  localparam int unsigned BIT_TX_FULL    = 3;
  localparam int unsigned BIT_RX_AVAIL   = 4;

  localparam logic [7:0] OFF_STATUS  = 8'h04;
  localparam logic [7:0] OFF_ENABLE  = 8'h08;
  localparam logic [7:0] OFF_DISABLE = 8'h0C;
  localparam logic [7:0] OFF_MASK    = 8'h10;
  localparam logic [7:0] OFF_WMARK   = 8'h28;

  typedef enum logic [1:0] {RD_NONE, RD_STATUS, RD_MASK, RD_WMARK} rdSel_e;

  typedef struct packed {
    logic   clrStatus;
    logic   setMask;
    logic   clrMask;
    logic   wrWmark;
    rdSel_e rdSel;
  } regStrobes_t;
endpackage

// File: rtl/spi_irq_ctrl.sv
`timescale 1ns/1ps
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobes_t       strobes
);
  always_comb begin
    strobes       = '0;
    strobes.rdSel = RD_NONE;
    if (regAddr == ADDR_W'(OFF_STATUS)) begin
      strobes.rdSel     = RD_STATUS;
      strobes.clrStatus = regWrEn;
    end else if (regAddr == ADDR_W'(OFF_ENABLE)) begin
      strobes.setMask = regWrEn;
    end else if (regAddr == ADDR_W'(OFF_DISABLE)) begin
      strobes.clrMask = regWrEn;
    end else if (regAddr == ADDR_W'(OFF_MASK)) begin
      strobes.rdSel = RD_MASK;
    end else if (regAddr == ADDR_W'(OFF_WMARK)) begin
      strobes.rdSel   = RD_WMARK;
      strobes.wrWmark = regWrEn;
    end
  end
endmodule

// File: rtl/spi_irq_dp.sv
`timescale 1ns/1ps
module spi_irq_dp
  import spi_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobes_t         strobes,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [LVL_W-1:0]    txLevel,
  input  logic [LVL_W-1:0]    rxLevel,
  input  logic                modeFault,
  output logic [IRQ_BITS-1:0] statusQ,
  output logic [IRQ_BITS-1:0] maskQ,
  output logic [DATA_W-1:0]   regRdData
);
  localparam logic [LVL_W-1:0] FULL_LVL  = LVL_W'(FIFO_DEPTH);
  localparam logic [LVL_W-1:0] WM_RESET  = LVL_W'(1);

  logic [LVL_W-1:0]    wmarkQ;
  logic                belowQ;
  logic                belowNow;
  logic [IRQ_BITS-1:0] eventVec;
  logic [IRQ_BITS-1:0] clrVec;
  logic [IRQ_BITS-1:0] wrBits;
  logic                unusedWrHigh;

  assign wrBits       = regWrData[IRQ_BITS-1:0];
  assign unusedWrHigh = ^regWrData[DATA_W-1:IRQ_BITS];
  assign belowNow     = txLevel < wmarkQ;
  assign clrVec       = strobes.clrStatus ? wrBits : '0;

  always_comb begin
    eventVec                 = '0;
    eventVec[BIT_MODE_FAULT] = modeFault;
    eventVec[BIT_TX_LOW]     = belowNow && !belowQ;
    eventVec[BIT_TX_FULL]    = txLevel == FULL_LVL;
    eventVec[BIT_RX_AVAIL]   = rxLevel != '0;
  end

  // Sticky status: a source active on the same edge outranks a clear.
  for (genvar b = 0; b < IRQ_BITS; b++) begin : gStatus
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statusQ[b] <= 1'b0;
      else       statusQ[b] <= eventVec[b] | (statusQ[b] & ~clrVec[b]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      wmarkQ <= WM_RESET;
      belowQ <= 1'b1;
    end else begin
      if (strobes.setMask)      maskQ <= maskQ | wrBits;
      else if (strobes.clrMask) maskQ <= maskQ & ~wrBits;
      if (strobes.wrWmark)      wmarkQ <= regWrData[LVL_W-1:0];
      belowQ <= belowNow;
    end
  end

  always_comb begin
    case (strobes.rdSel)
      RD_STATUS: regRdData = DATA_W'(statusQ);
      RD_MASK:   regRdData = DATA_W'(maskQ);
      RD_WMARK:  regRdData = DATA_W'(wmarkQ);
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_regbank.sv
`timescale 1ns/1ps
module spi_irq_regbank
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              modeFault,
  output logic              irqOut
);
  regStrobes_t         strobes;
  logic [IRQ_BITS-1:0] statusQ;
  logic [IRQ_BITS-1:0] maskQ;

  spi_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes)
  );

  spi_irq_dp #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regWrData (regWrData),
    .txLevel   (txLevel),
    .rxLevel   (rxLevel),
    .modeFault (modeFault),
    .statusQ   (statusQ),
    .maskQ     (maskQ),
    .regRdData (regRdData)
  );

  assign irqOut = |(statusQ & maskQ);
endmodule

// File: rtl/spi_irq_checker.sv
`timescale 1ns/1ps
module spi_irq_checker
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWrEn,
  input logic [DATA_W-1:0]   regWrData,
  input logic [LVL_W-1:0]    txLevel,
  input logic [LVL_W-1:0]    rxLevel,
  input logic                modeFault,
  input logic                irqOut,
  input logic [IRQ_BITS-1:0] statusQ,
  input logic [IRQ_BITS-1:0] maskQ
);
  logic wrEnable, wrDisable, wrMaskView, wrStatus;
  assign wrEnable   = regWrEn && regAddr == ADDR_W'(OFF_ENABLE);
  assign wrDisable  = regWrEn && regAddr == ADDR_W'(OFF_DISABLE);
  assign wrMaskView = regWrEn && regAddr == ADDR_W'(OFF_MASK);
  assign wrStatus   = regWrEn && regAddr == ADDR_W'(OFF_STATUS);

  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEnable |=> ((maskQ & $past(regWrData[IRQ_BITS-1:0])) == $past(regWrData[IRQ_BITS-1:0])));

  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrDisable |=> ((maskQ & $past(regWrData[IRQ_BITS-1:0])) == '0));

  assert_mask_view_ro_R11: assert property (@(posedge clk) disable iff (!rstN)
    wrMaskView |=> $stable(maskQ));

  assert_mode_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |=> statusQ[BIT_MODE_FAULT]);

  assert_tx_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel == LVL_W'(FIFO_DEPTH)) |=> statusQ[BIT_TX_FULL]);

  assert_rx_avail_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel != '0) |=> statusQ[BIT_RX_AVAIL]);

  assert_wmark_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[BIT_TX_LOW] && !(wrStatus && regWrData[BIT_TX_LOW])) |=> statusQ[BIT_TX_LOW]);

  assert_no_irq_unmasked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irqOut);
endmodule

bind spi_irq_regbank spi_irq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
) chk_i (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
  .txLevel(txLevel), .rxLevel(rxLevel), .modeFault(modeFault), .irqOut(irqOut),
  .statusQ(statusQ), .maskQ(maskQ)
);

// File: tb/spi_irq_regbank_tb_top.sv
`timescale 1ns/1ps
module spi_irq_regbank_tb_top;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  localparam logic [ADDR_W-1:0] A_STATUS = 6'h04;
  localparam logic [ADDR_W-1:0] A_EN     = 6'h08;
  localparam logic [ADDR_W-1:0] A_DIS    = 6'h0C;
  localparam logic [ADDR_W-1:0] A_MASK   = 6'h10;
  localparam logic [ADDR_W-1:0] A_WM     = 6'h28;
  localparam logic [ADDR_W-1:0] A_NONE   = 6'h30;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWrEn = 1'b0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic [LVL_W-1:0]  txLevel = '0;
  logic [LVL_W-1:0]  rxLevel = '0;
  logic              modeFault = 1'b0;
  logic              irqOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  spi_irq_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .txLevel(txLevel), .rxLevel(rxLevel), .modeFault(modeFault),
    .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = A_NONE;
  endtask

  task automatic readReg(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
    regAddr = A_NONE;
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] snap;
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    readReg(A_STATUS, rd); check("R1 status", rd, 0);
    readReg(A_MASK, rd);   check("R1 mask", rd, 0);
    readReg(A_WM, rd);     check("R1 watermark", rd, 1);
    check("R1 irq", {31'b0, irqOut}, 0);

    // R2 enable sweep and zero write
    for (int v = 0; v < 128; v++) begin
      writeReg(A_DIS, 32'h7F);
      writeReg(A_EN, v);
      readReg(A_MASK, rd); check("R2 enable sets", rd, v);
    end
    writeReg(A_DIS, 32'h7F); writeReg(A_EN, 32'h55); writeReg(A_EN, 32'h0);
    readReg(A_MASK, rd); check("R2 zero enable", rd, 32'h55);

    // R3 disable sweep and zero write
    for (int v = 0; v < 128; v++) begin
      writeReg(A_EN, 32'h7F);
      writeReg(A_DIS, v);
      readReg(A_MASK, rd); check("R3 disable clears", rd, 32'h7F & ~v);
    end
    writeReg(A_EN, 32'h7F); writeReg(A_DIS, 32'h0);
    readReg(A_MASK, rd); check("R3 zero disable", rd, 32'h7F);

    // R11 write-only reads, read-only mask writes, unmapped reads
    writeReg(A_MASK, 32'h0);
    readReg(A_MASK, rd); check("R11 mask view write ignored", rd, 32'h7F);
    readReg(A_EN, rd);   check("R11 enable reads zero", rd, 0);
    readReg(A_DIS, rd);  check("R11 disable reads zero", rd, 0);
    readReg(A_NONE, rd); check("R11 unmapped reads zero", rd, 0);
    writeReg(A_DIS, 32'h7F);

    // R9 watermark read/write
    for (int t = 0; t < 16; t++) begin
      writeReg(A_WM, 32'hFFFF_FFF0 | t);
      readReg(A_WM, rd); check("R9 watermark", rd, t);
    end

    // R8 watermark crossing sweep, thresholds 0..DEPTH
    for (int t = 0; t <= DEPTH; t++) begin
      txLevel = LVL_W'(DEPTH); step(1);
      writeReg(A_WM, t); step(1);
      writeReg(A_STATUS, 32'h7F);
      for (int l = DEPTH - 1; l >= 0; l--) begin
        txLevel = LVL_W'(l); step(1);
        readReg(A_STATUS, rd);
        check("R8 below watermark", {31'b0, rd[2]}, (l < t) ? 1 : 0);
      end
      writeReg(A_STATUS, 32'h04); step(3);
      readReg(A_STATUS, rd); check("R8 no retrigger while below", {31'b0, rd[2]}, 0);
    end
    // R8 latched while level rises again
    writeReg(A_WM, 4); txLevel = 4'd6; step(2);
    writeReg(A_STATUS, 32'h7F);
    txLevel = 4'd2; step(1); txLevel = 4'd7; step(3);
    readReg(A_STATUS, rd); check("R8 latched after rise", {31'b0, rd[2]}, 1);

    // R5 mode fault
    writeReg(A_STATUS, 32'h7F);
    modeFault = 1'b1; step(1); modeFault = 1'b0; step(3);
    readReg(A_STATUS, rd); check("R5 mode fault latched", rd, 32'h02);

    // R6 tx full
    txLevel = LVL_W'(DEPTH); step(1); txLevel = 4'd5; step(1);
    readReg(A_STATUS, rd); check("R6 tx full", rd, 32'h0A);

    // R4 write back clears exactly
    writeReg(A_STATUS, 32'h08);
    readReg(A_STATUS, rd); check("R4 partial clear", rd, 32'h02);
    txLevel = LVL_W'(DEPTH); step(1); txLevel = 4'd5; step(1);
    readReg(A_STATUS, snap);
    writeReg(A_STATUS, snap);
    readReg(A_STATUS, rd); check("R4 write back", rd, 0);

    // R7 rx available, clear blocked while nonempty
    rxLevel = 4'd3; step(1);
    readReg(A_STATUS, rd); check("R7 rx avail", rd, 32'h10);
    writeReg(A_STATUS, 32'h10);
    readReg(A_STATUS, rd); check("R7 clear while nonempty", rd, 32'h10);
    rxLevel = 4'd0; step(1);
    writeReg(A_STATUS, 32'h10);
    readReg(A_STATUS, rd); check("R7 clear when empty", rd, 0);

    // R12 set wins over clear on same edge
    modeFault = 1'b1; step(1);
    writeReg(A_STATUS, 32'h02);
    readReg(A_STATUS, rd); check("R12 set beats clear", rd, 32'h02);
    modeFault = 1'b0; step(1);
    writeReg(A_STATUS, 32'h02);
    readReg(A_STATUS, rd); check("R12 clear after source drops", rd, 0);

    // R10 irq sweep over masks with two status patterns
    writeReg(A_WM, 1);
    modeFault = 1'b1; step(1); modeFault = 1'b0;
    txLevel = LVL_W'(DEPTH); step(1); txLevel = 4'd5; step(1);
    readReg(A_STATUS, rd); check("R10 setup status", rd, 32'h0A);
    for (int m = 0; m < 128; m++) begin
      writeReg(A_DIS, 32'h7F); writeReg(A_EN, m);
      check("R10 irq pattern A", {31'b0, irqOut}, ((m & 32'h0A) != 0) ? 1 : 0);
    end
    rxLevel = 4'd1; step(1);
    for (int m = 0; m < 128; m++) begin
      writeReg(A_DIS, 32'h7F); writeReg(A_EN, m);
      check("R10 irq pattern B", {31'b0, irqOut}, ((m & 32'h1A) != 0) ? 1 : 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule